// File: doc/BRIEF.md
# Step-Enabled Delay Line with Selectable Reload Trigger

The block delays a stream of samples by a fixed number of steps. A step happens on each clock cycle in which `step_en` is high. The sample presented on `din` at a step comes out on `dout` exactly `DEPTH` steps later. Until the line has been filled with real samples, the output shows initial-condition values. These values come either from the `IC_INIT` parameter or from the `ic_in` port, depending on `IC_SRC`.

A `reload` input refills the line with the initial condition whenever its activity matches the trigger rule chosen by the `ALGO` parameter. The rules are none, rising edge, falling edge, any change, level with one trailing step, and pure level. The edge rules, and the level rule with a trailing step, compare `reload` against a stored copy of its value from the previous enabled step. Pure level and none keep no such copy. `dout` is always driven from the stage memory, or from the initial condition on a reload step. It is never taken directly from `din`.

Top module: `step_delay_line`

## Requirements
- R1: With no trigger during the last `DEPTH` enabled steps, `dout` during an enabled step equals the `din` value sampled `DEPTH` enabled steps earlier.
- R2: While `step_en` is low, nothing shifts, `dout` holds its value and the stored previous `reload` value is not updated. A `reload` edge that starts and ends entirely between enabled steps is therefore not seen by the edge rules.
- R3: After `rst_n` is released and up to and including the first enabled step, `dout` shows initial-condition field `DEPTH-1`. Steps that follow show fields `DEPTH-2` down to 0, and after that the delayed samples. Field i occupies bits `[i*DATA_W +: DATA_W]`.
- R4: With `IC_SRC = IC_FIXED` the initial condition is `IC_INIT` and `ic_in` is ignored. With `IC_SRC = IC_PORT` it is the value on `ic_in` in the trigger step.
- R5: With `ALGO = TRG_NONE` (code 0), `reload` has no effect on `dout`.
- R6: `TRG_RISE` (code 1) triggers on an enabled step where `reload` is 1 and the stored previous value is 0.
- R7: `TRG_FALL` (code 2) triggers on an enabled step where `reload` is 0 and the stored previous value is 1.
- R8: `TRG_ANY` (code 3) triggers on an enabled step where `reload` differs from the stored previous value.
- R9: `TRG_LEVEL` (code 4) triggers on an enabled step where `reload` is 1, or where the stored previous value is 1.
- R10: `TRG_HOLD` (code 5) triggers on every enabled step where `reload` is 1.
- R11: On a trigger step, `dout` shows field `DEPTH-1`. The following steps show fields `DEPTH-2` down to 0, and the `din` sample of the trigger step appears `DEPTH` steps later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through two flops |
| step_en | input | 1 | Advances the line by one step in this cycle |
| reload | input | 1 | Reload request, interpreted by `ALGO` |
| din | input | DATA_W | Sample entering the line |
| ic_in | input | DEPTH*DATA_W | Initial-condition fields (used only with `IC_PORT`) |
| dout | output | DATA_W | Delayed sample or initial-condition field |

## Verification
On every cycle, the checker confirms three things. The output holds across idle cycles. It shows the oldest initial-condition field before the first step. It shows that field on any step whose `reload` activity matches the configured rule, judged against a previous-value tracker the checker keeps itself. Several properties are beyond a single-cycle check. These are the full delay distance, the ordering of initial-condition fields after a reload, sampling of the port at the reload step, and edges that go unseen because they fell between enabled steps. Only the bench's long mixed sequence shows them, run on six fixed-source instances and one port-sourced instance side by side.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  typedef enum logic [2:0] {
    TRG_NONE  = 3'd0,
    TRG_RISE  = 3'd1,
    TRG_FALL  = 3'd2,
    TRG_ANY   = 3'd3,
    TRG_LEVEL = 3'd4,
    TRG_HOLD  = 3'd5
  } trig_algo_e;

  typedef enum logic {
    IC_FIXED = 1'b0,
    IC_PORT  = 1'b1
  } ic_src_e;

  // Rules that compare against the value seen at the previous enabled step.
  function automatic bit needs_prev(trig_algo_e a);
    return (a == TRG_RISE) || (a == TRG_FALL) || (a == TRG_ANY) || (a == TRG_LEVEL);
  endfunction

  function automatic logic fires(trig_algo_e a, logic now_v, logic before_v);
    logic f;
    case (a)
      TRG_RISE:  f = now_v & ~before_v;
      TRG_FALL:  f = ~now_v & before_v;
      TRG_ANY:   f = now_v ^ before_v;
      TRG_LEVEL: f = now_v | before_v;
      TRG_HOLD:  f = now_v;
      default:   f = 1'b0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/sdl_trigger.sv
module sdl_trigger
  import sdl_pkg::*;
#(
  parameter trig_algo_e ALGO = TRG_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic reload,
  output logic hit
);

  logic prev;

  generate
    if (needs_prev(ALGO)) begin : g_prev
      logic prev_q;
      logic prev_d;

      always_comb begin
        prev_d = prev_q;
        if (step_en) prev_d = reload;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
      end

      assign prev = prev_q;
    end else begin : g_noprev
      logic unused_trig;
      assign unused_trig = ^{clk, rst_n, step_en};
      assign prev = 1'b0;
    end
  endgenerate

  assign hit = fires(ALGO, reload, prev);

endmodule

// File: rtl/sdl_ic_select.sv
module sdl_ic_select
  import sdl_pkg::*;
#(
  parameter int                        DATA_W  = 8,
  parameter int                        DEPTH   = 4,
  parameter ic_src_e                   IC_SRC  = IC_FIXED,
  parameter logic [DEPTH*DATA_W-1:0]   IC_INIT = '0
) (
  input  logic [DEPTH*DATA_W-1:0] ic_port,
  output logic [DEPTH*DATA_W-1:0] ic_vec
);

  generate
    if (IC_SRC == IC_PORT) begin : g_port
      assign ic_vec = ic_port;
    end else begin : g_fixed
      logic unused_port;
      assign unused_port = ^ic_port;
      assign ic_vec = IC_INIT;
    end
  endgenerate

endmodule

// File: rtl/sdl_stages.sv
module sdl_stages #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_en,
  input  logic                    load,
  input  logic [DEPTH*DATA_W-1:0] ic_vec,
  input  logic [DATA_W-1:0]       din,
  output logic [DATA_W-1:0]       oldest
);

  localparam int LAST = DEPTH - 1;

  logic [DATA_W-1:0] stage_q [DEPTH];
  logic [DATA_W-1:0] stage_d [DEPTH];

  // Stage 0 is the newest sample; a load behaves as if the line had just
  // been filled with the initial condition before this step's shift.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) stage_d[i] = stage_q[i];
    if (step_en) begin
      stage_d[0] = din;
      for (int i = 1; i < DEPTH; i++)
        stage_d[i] = load ? ic_vec[(i-1)*DATA_W +: DATA_W] : stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign oldest = stage_q[LAST];

endmodule

// File: rtl/step_delay_line.sv
module step_delay_line
  import sdl_pkg::*;
#(
  parameter int                      DATA_W  = 8,
  parameter int                      DEPTH   = 4,
  parameter trig_algo_e              ALGO    = TRG_RISE,
  parameter ic_src_e                 IC_SRC  = IC_FIXED,
  parameter logic [DEPTH*DATA_W-1:0] IC_INIT = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_en,
  input  logic                    reload,
  input  logic [DATA_W-1:0]       din,
  input  logic [DEPTH*DATA_W-1:0] ic_in,
  output logic [DATA_W-1:0]       dout
);

  localparam int OLD_LSB = (DEPTH - 1) * DATA_W;

  // Asynchronous assertion, synchronous release.
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_core_n = rst_pipe_q[1];

  // Set until the first enabled step: that step loads the initial condition.
  logic fresh_q;
  logic fresh_d;

  always_comb begin
    fresh_d = fresh_q;
    if (step_en) fresh_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) fresh_q <= 1'b1;
    else             fresh_q <= fresh_d;
  end

  logic                    hit;
  logic                    load;
  logic [DEPTH*DATA_W-1:0] ic_vec;
  logic [DATA_W-1:0]       stage_old;

  sdl_trigger #(
    .ALGO (ALGO)
  ) u_trig (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .step_en (step_en),
    .reload  (reload),
    .hit     (hit)
  );

  sdl_ic_select #(
    .DATA_W  (DATA_W),
    .DEPTH   (DEPTH),
    .IC_SRC  (IC_SRC),
    .IC_INIT (IC_INIT)
  ) u_ic (
    .ic_port (ic_in),
    .ic_vec  (ic_vec)
  );

  assign load = fresh_q | hit;

  sdl_stages #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_stages (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .step_en (step_en),
    .load    (load),
    .ic_vec  (ic_vec),
    .din     (din),
    .oldest  (stage_old)
  );

  always_comb begin
    if (fresh_q || (step_en && hit)) dout = ic_vec[OLD_LSB +: DATA_W];
    else                             dout = stage_old;
  end

endmodule

// File: rtl/step_delay_line_chk.sv
module step_delay_line_chk
  import sdl_pkg::*;
#(
  parameter int         DATA_W = 8,
  parameter int         DEPTH  = 4,
  parameter trig_algo_e ALGO   = TRG_RISE
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    step_en,
  input logic                    reload,
  input logic [DATA_W-1:0]       dout,
  input logic [DEPTH*DATA_W-1:0] ic_vec
);

  localparam int OLD_LSB = (DEPTH - 1) * DATA_W;

  logic              first_q;
  logic              seen_q;
  logic              last_r_q;
  logic [DATA_W-1:0] ic_old;

  assign ic_old = ic_vec[OLD_LSB +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= 1'b1;
      seen_q   <= 1'b0;
      last_r_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (step_en) begin
        first_q  <= 1'b0;
        last_r_q <= reload;
      end
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !first_q && !step_en && $past(!step_en)) |-> $stable(dout)); // R2

  AST_FIRST_IC: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |-> (dout == ic_old)); // R3

  AST_RISE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((ALGO == TRG_RISE) && step_en && reload && !last_r_q) |-> (dout == ic_old)); // R6

  AST_FALL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((ALGO == TRG_FALL) && step_en && !reload && last_r_q) |-> (dout == ic_old)); // R7

  AST_ANY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((ALGO == TRG_ANY) && step_en && (reload != last_r_q)) |-> (dout == ic_old)); // R8

  AST_LEVEL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((ALGO == TRG_LEVEL) && step_en && (reload || last_r_q)) |-> (dout == ic_old)); // R9

  AST_HOLD_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((ALGO == TRG_HOLD) && step_en && reload) |-> (dout == ic_old)); // R10

endmodule

bind step_delay_line step_delay_line_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .ALGO   (ALGO)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .step_en (step_en),
  .reload  (reload),
  .dout    (dout),
  .ic_vec  (ic_vec)
);

// File: tb/step_delay_line_tb.sv
`timescale 1ns/1ps
module step_delay_line_tb;
  import sdl_pkg::*;

  localparam int W  = 8;
  localparam int D  = 3;
  localparam int ND = 7;
  localparam logic [D*W-1:0] ICS = 24'hC3B2A1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst_n;
  logic           step_en;
  logic           reload;
  logic [W-1:0]   din;
  logic [D*W-1:0] ic_in;
  logic [W-1:0]   dout_v [ND];

  function automatic trig_algo_e algo_of(int g);
    case (g)
      1: return TRG_RISE;
      2: return TRG_FALL;
      3: return TRG_ANY;
      4: return TRG_LEVEL;
      5: return TRG_HOLD;
      6: return TRG_ANY;
      default: return TRG_NONE;
    endcase
  endfunction

  generate
    for (genvar g = 0; g < ND; g++) begin : g_dut
      step_delay_line #(
        .DATA_W  (W),
        .DEPTH   (D),
        .ALGO    (algo_of(g)),
        .IC_SRC  ((g == 6) ? IC_PORT : IC_FIXED),
        .IC_INIT (ICS)
      ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .reload  (reload),
        .din     (din),
        .ic_in   (ic_in),
        .dout    (dout_v[g])
      );
    end
  endgenerate

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Reference model state, per instance
  bit          fresh_m [ND];
  bit          prev_m  [ND];
  int          since_m [ND];
  logic [W-1:0] icm    [ND][D];
  logic [W-1:0] uhist  [0:1023];
  int          nstep;

  function automatic bit fires_m(int a, bit r, bit p);
    case (a)
      1: return r && !p;
      2: return !r && p;
      3: return r != p;
      4: return r || p;
      5: return r;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(int d, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s dut%0d actual=%h expected=%h (step %0d)", tag, d, act, exp, nstep);
    end
  endtask

  task automatic do_cycle(bit en, bit r, logic [W-1:0] u, logic [D*W-1:0] icp);
    string tags [6] = '{"R5", "R6", "R7", "R8", "R9", "R10"};
    @(negedge clk);
    step_en = en; reload = r; din = u; ic_in = icp;
    #2;
    for (int d = 0; d < ND; d++) begin
      int a;
      bit hm;
      logic [D*W-1:0] icsrc;
      logic [W-1:0] exp;
      string tag;
      a = (d == 6) ? 3 : d;
      icsrc = (d == 6) ? icp : ICS;
      hm = fresh_m[d] || fires_m(a, r, prev_m[d]);
      if (fresh_m[d] || (en && hm)) exp = icsrc[(D-1)*W +: W];
      else if (since_m[d] < D)      exp = icm[d][D-1-since_m[d]];
      else                          exp = uhist[nstep-D];
      if (fresh_m[d])          tag = "R3";
      else if (!en)            tag = "R2";
      else if (d == 6)         tag = "R4";
      else if (hm)             tag = tags[a];
      else if (d == 0 && r)    tag = "R5";
      else if (since_m[d] < D) tag = "R11";
      else                     tag = "R1";
      check(d, tag, dout_v[d], exp);
      if (en) begin
        if (hm) begin
          for (int k = 0; k < D; k++) icm[d][k] = icsrc[k*W +: W];
          since_m[d] = 1;
        end else if (since_m[d] < D) begin
          since_m[d]++;
        end
        prev_m[d]  = r;
        fresh_m[d] = 1'b0;
      end
    end
    if (en) begin
      uhist[nstep] = u;
      nstep++;
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    bit r;
    rst_n = 1'b0; step_en = 1'b0; reload = 1'b0; din = '0; ic_in = '0;
    nstep = 0;
    for (int d = 0; d < ND; d++) begin
      fresh_m[d] = 1'b1; prev_m[d] = 1'b0; since_m[d] = D;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 / R2: idle cycles after reset, reload wiggling, port IC changing
    for (int i = 0; i < 5; i++) do_cycle(1'b0, i[0], 8'h5A, {8'h10 + 8'(i), 8'h20, 8'h30});
    lfsr = 16'hACE1;
    r = 1'b0;
    for (int i = 0; i < 900; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:1] == 3'd0 || lfsr[9:7] == 3'd5) r = ~r;
      do_cycle(lfsr[5:4] != 2'b00, r, lfsr[15:8] ^ 8'(i), {lfsr, 8'(i)});
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule